// File: doc/BRIEF.md
# I2C Status and Interrupt Flag Controller

This block keeps the three status flags of a multi-master I2C controller that hardware updates by itself: an active-low byte-complete flag, a bus-busy flag and a transmit/receive direction flag. The byte-complete flag drops when the shift engine reports the end of a byte. While it is low, the block requests that SCL be held low. Software releases it through register write strobes. An interrupt request pulses on each falling transition of that flag.

The bus-busy flag is derived only from the SCL and SDA pin levels. Both lines pass through synchronizer chains. Start and stop conditions are then detected on SDA edges while SCL is high, and SCL must have been high for a programmable number of cycles first. The direction flag is written by software. A fixed set of hardware events overrides it: an address match for a slave read sets it, and several bus events clear it. The bit shifter, the clock generator, the address comparator and the arbitration detector sit outside this block and report to it through single-cycle event strobes.

Top module: `i2c_flag_ctrl`

## Requirements
- R1: After reset, `pend_n` = 1, `bus_busy` = 0, `dir_tx` = 0, `irq` = 0 and `scl_hold` = 0.
- R2: A `byte_done` strobe drives `pend_n` to 0 at the next clock edge. `irq` is high for exactly the one cycle in which `pend_n` first reads 0, and is never high otherwise.
- R3: `scl_hold` is 1 exactly while `pend_n` is 0.
- R4: A `wr_data` strobe returns `pend_n` to 1 at the next edge. If a clear event arrives in the same cycle, the clear wins and `pend_n` goes to 0.
- R5: When `ack_clk_mode` = 1 and `wait_en` = 1, a `data_done` strobe clears `pend_n` and arms an internal wait flag. A `wr_clkctl` strobe returns `pend_n` to 1 only while `wait_en` = 1 and the wait flag is armed. Otherwise `wr_clkctl` has no effect on `pend_n`. With `wait_en` = 0, `data_done` has no effect.
- R6: An `addr_done` strobe while `is_master` = 0 clears `pend_n` in two cases. With `addr_free` = 0, it must come with `addr_match` or `gen_call`. With `addr_free` = 1, it always clears. While `is_master` = 1, it has no effect.
- R7: `start_det` pulses and `bus_busy` becomes 1 when the synchronized SDA falls while the synchronized SCL is high and has been high for at least `scl_hi_min` cycles. `stop_det` pulses and `bus_busy` becomes 0 on the matching SDA rise. An SDA edge while SCL is low, or after a shorter SCL high time, is ignored.
- R8: While `en` = 0, `pend_n` is forced to 1, `bus_busy` and `dir_tx` to 0, and the wait flag is disarmed. No bus conditions are detected in that state.
- R9: When `is_master` = 0, `addr_free` = 0 and `addr_match` and `rx_rw` are both 1, `dir_tx` is set to 1.
- R10: `dir_tx` is cleared by any of these: `arb_lost`, a detected stop, `start_blocked`, a detected start while `is_master` = 0, or `nack` while `is_master` = 0. A start detected while `is_master` = 1 leaves it unchanged.
- R11: `dir_wr` loads `dir_val` into `dir_tx`. A hardware set or clear in the same cycle takes priority, and a clear beats a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Module enable |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| scl_hi_min | input | FILT_W | Minimum SCL high cycles before a start or stop is accepted |
| is_master | input | 1 | Controller currently acts as master |
| addr_free | input | 1 | Address-free mode: every address byte completes |
| ack_clk_mode | input | 1 | ACK clock is generated |
| wait_en | input | 1 | Pause before the ACK clock |
| byte_done | input | 1 | Falling edge of the last clock of a byte, including ACK |
| data_done | input | 1 | Falling edge of the last data bit clock |
| addr_done | input | 1 | Slave address byte received |
| addr_match | input | 1 | Own slave address matched |
| gen_call | input | 1 | General call address received |
| rx_rw | input | 1 | Received read/write bit |
| arb_lost | input | 1 | Arbitration lost |
| nack | input | 1 | No acknowledge returned |
| start_blocked | input | 1 | Start suppressed by duplicate-start prevention |
| wr_data | input | 1 | Software write to the data shift register |
| wr_clkctl | input | 1 | Software write to the clock control register |
| dir_wr | input | 1 | Software write to the direction flag |
| dir_val | input | 1 | Value written to the direction flag |
| pend_n | output | 1 | Byte-complete flag, active low |
| irq | output | 1 | Interrupt request pulse |
| scl_hold | output | 1 | Request to hold SCL low |
| bus_busy | output | 1 | Bus busy flag |
| dir_tx | output | 1 | Direction flag, 1 = transmit |
| start_det | output | 1 | Start condition detected, single-cycle pulse |
| stop_det | output | 1 | Stop condition detected, single-cycle pulse |

## Verification
The flag clear paths are each driven alone and then paired with a release write in the same cycle. This separates a correct priority from a reversed one. The wait path is tried with the wait enable on and off, and with the clock-control write before and after arming, which exposes a release that ignores the wait flag. Bus patterns include a proper start and stop, an SDA fall while SCL is low, and an SDA fall shortly after SCL rises, first with a nonzero filter and then with zero. Together these show that the filter and the SCL qualifier are both in effect. The direction clear list is walked one event at a time, with a master start as the negative case.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;

  typedef logic [15:0] cnt_t;

  // Saturating increment used by the SCL high-time filter.
  function automatic cnt_t sat_inc(cnt_t c, cnt_t lim);
    return (c >= lim) ? lim : c + 16'd1;
  endfunction

  // SCL has been high long enough to qualify an SDA edge.
  function automatic logic filt_ok(cnt_t c, cnt_t min_hi);
    return c >= min_hi;
  endfunction

  // Hardware reasons to drop the direction flag.
  typedef struct packed {
    logic arb;
    logic stop;
    logic blocked;
    logic slv_start;
    logic slv_nack;
  } dir_clr_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
  import i2c_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [FILT_W-1:0] scl_hi_min,
  output logic              start_det,
  output logic              stop_det,
  output logic              busy
);
  localparam cnt_t CNT_MAX = cnt_t'((1 << FILT_W) - 1);

  logic scl_s, sda_s, sda_d, scl_ok;
  logic [FILT_W-1:0] hi_cnt;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_d  <= 1'b1;
      hi_cnt <= '0;
    end else begin
      sda_d  <= sda_s;
      hi_cnt <= scl_s ? FILT_W'(sat_inc(cnt_t'(hi_cnt), CNT_MAX)) : '0;
    end
  end

  assign scl_ok    = scl_s & filt_ok(cnt_t'(hi_cnt), cnt_t'(scl_hi_min));
  assign start_det = en & scl_ok & sda_d & ~sda_s;
  assign stop_det  = en & scl_ok & ~sda_d & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy <= 1'b0;
    else if (!en)       busy <= 1'b0;
    else if (start_det) busy <= 1'b1;
    else if (stop_det)  busy <= 1'b0;
  end
endmodule

// File: rtl/i2c_pend_unit.sv
module i2c_pend_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic is_master,
  input  logic addr_free,
  input  logic ack_clk_mode,
  input  logic wait_en,
  input  logic byte_done,
  input  logic data_done,
  input  logic addr_done,
  input  logic addr_match,
  input  logic gen_call,
  input  logic wr_data,
  input  logic wr_clkctl,
  output logic pend_n,
  output logic irq,
  output logic clr_ev,
  output logic set_ev
);
  logic wait_q, clr_wait, clr_addr, rel_clk, pend_d;

  assign clr_wait = data_done & ack_clk_mode & wait_en;
  assign clr_addr = addr_done & ~is_master & (addr_free | addr_match | gen_call);
  assign clr_ev   = byte_done | clr_wait | clr_addr;
  assign rel_clk  = wr_clkctl & wait_en & wait_q;
  assign set_ev   = wr_data | rel_clk;

  always_comb begin
    if (!en)         pend_d = 1'b1;
    else if (clr_ev) pend_d = 1'b0;
    else if (set_ev) pend_d = 1'b1;
    else             pend_d = pend_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_n <= 1'b1;
      irq    <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      pend_n <= pend_d;
      irq    <= pend_n & ~pend_d;
      if (!en)                     wait_q <= 1'b0;
      else if (clr_wait)           wait_q <= 1'b1;
      else if (set_ev && !clr_ev)  wait_q <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_dir_unit.sv
module i2c_dir_unit
  import i2c_flag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic is_master,
  input  logic addr_free,
  input  logic addr_match,
  input  logic rx_rw,
  input  logic arb_lost,
  input  logic stop_det,
  input  logic start_det,
  input  logic start_blocked,
  input  logic nack,
  input  logic dir_wr,
  input  logic dir_val,
  output logic dir_tx,
  output logic hw_clr,
  output logic hw_set
);
  dir_clr_t why;

  assign why.arb       = arb_lost;
  assign why.stop      = stop_det;
  assign why.blocked   = start_blocked;
  assign why.slv_start = start_det & ~is_master;
  assign why.slv_nack  = nack & ~is_master;
  assign hw_clr        = |why;
  assign hw_set        = ~is_master & ~addr_free & addr_match & rx_rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_tx <= 1'b0;
    else if (!en)    dir_tx <= 1'b0;
    else if (hw_clr) dir_tx <= 1'b0;
    else if (hw_set) dir_tx <= 1'b1;
    else if (dir_wr) dir_tx <= dir_val;
  end
endmodule

// File: rtl/i2c_flag_ctrl.sv
module i2c_flag_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [FILT_W-1:0] scl_hi_min,
  input  logic              is_master,
  input  logic              addr_free,
  input  logic              ack_clk_mode,
  input  logic              wait_en,
  input  logic              byte_done,
  input  logic              data_done,
  input  logic              addr_done,
  input  logic              addr_match,
  input  logic              gen_call,
  input  logic              rx_rw,
  input  logic              arb_lost,
  input  logic              nack,
  input  logic              start_blocked,
  input  logic              wr_data,
  input  logic              wr_clkctl,
  input  logic              dir_wr,
  input  logic              dir_val,
  output logic              pend_n,
  output logic              irq,
  output logic              scl_hold,
  output logic              bus_busy,
  output logic              dir_tx,
  output logic              start_det,
  output logic              stop_det
);
  // Named internal events, visible to the bound checker.
  logic pend_clr_ev, pend_set_ev, dir_hw_clr, dir_hw_set;

  i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_W(FILT_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in), .sda_in(sda_in),
    .scl_hi_min(scl_hi_min), .start_det(start_det), .stop_det(stop_det),
    .busy(bus_busy));

  i2c_pend_unit u_pend (
    .clk(clk), .rst_n(rst_n), .en(en), .is_master(is_master),
    .addr_free(addr_free), .ack_clk_mode(ack_clk_mode), .wait_en(wait_en),
    .byte_done(byte_done), .data_done(data_done), .addr_done(addr_done),
    .addr_match(addr_match), .gen_call(gen_call), .wr_data(wr_data),
    .wr_clkctl(wr_clkctl), .pend_n(pend_n), .irq(irq),
    .clr_ev(pend_clr_ev), .set_ev(pend_set_ev));

  i2c_dir_unit u_dir (
    .clk(clk), .rst_n(rst_n), .en(en), .is_master(is_master),
    .addr_free(addr_free), .addr_match(addr_match), .rx_rw(rx_rw),
    .arb_lost(arb_lost), .stop_det(stop_det), .start_det(start_det),
    .start_blocked(start_blocked), .nack(nack), .dir_wr(dir_wr),
    .dir_val(dir_val), .dir_tx(dir_tx), .hw_clr(dir_hw_clr),
    .hw_set(dir_hw_set));

  assign scl_hold = ~pend_n;
endmodule

// File: rtl/i2c_flag_ctrl_chk.sv
module i2c_flag_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic wr_data,
  input logic pend_n,
  input logic irq,
  input logic scl_hold,
  input logic bus_busy,
  input logic dir_tx,
  input logic start_det,
  input logic stop_det,
  input logic pend_clr_ev,
  input logic dir_hw_clr,
  input logic dir_hw_set
);
  AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_n) |-> irq); // R2
  AST_IRQ_ONLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $fell(pend_n)); // R2
  AST_HOLD_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_n |-> scl_hold); // R3
  AST_DATA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    en && wr_data && !pend_clr_ev |=> pend_n); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    en && pend_clr_ev |=> !pend_n); // R4
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> bus_busy); // R7
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !bus_busy); // R7
  AST_DISABLE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pend_n && !bus_busy && !dir_tx); // R8
  AST_DIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    en && dir_hw_set && !dir_hw_clr |=> dir_tx); // R9
  AST_DIR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    en && dir_hw_clr |=> !dir_tx); // R10
endmodule

bind i2c_flag_ctrl i2c_flag_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_data(wr_data), .pend_n(pend_n),
  .irq(irq), .scl_hold(scl_hold), .bus_busy(bus_busy), .dir_tx(dir_tx),
  .start_det(start_det), .stop_det(stop_det), .pend_clr_ev(pend_clr_ev),
  .dir_hw_clr(dir_hw_clr), .dir_hw_set(dir_hw_set));

// File: tb/i2c_flag_ctrl_tb.sv
module i2c_flag_ctrl_tb;
  localparam int FILT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, scl_in = 1'b1, sda_in = 1'b1;
  logic [FILT_W-1:0] scl_hi_min = 4'd3;
  logic is_master = 1'b0, addr_free = 1'b0, ack_clk_mode = 1'b0, wait_en = 1'b0;
  logic byte_done = 1'b0, data_done = 1'b0, addr_done = 1'b0, addr_match = 1'b0;
  logic gen_call = 1'b0, rx_rw = 1'b0, arb_lost = 1'b0, nack = 1'b0;
  logic start_blocked = 1'b0, wr_data = 1'b0, wr_clkctl = 1'b0;
  logic dir_wr = 1'b0, dir_val = 1'b0;
  logic pend_n, irq, scl_hold, bus_busy, dir_tx, start_det, stop_det;

  int n_cmp = 0;
  int n_bad = 0;
  bit saw_start;

  always #10 clk = ~clk;

  i2c_flag_ctrl #(.FILT_W(FILT_W)) u_dut (.*);

  always @(negedge clk) if (start_det) saw_start = 1'b1;

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_strobes();
    byte_done = 0; data_done = 0; addr_done = 0; addr_match = 0; gen_call = 0;
    rx_rw = 0; arb_lost = 0; nack = 0; start_blocked = 0; wr_data = 0;
    wr_clkctl = 0; dir_wr = 0; dir_val = 0;
  endtask

  task automatic release_pend();
    wr_data = 1; tick(); clear_strobes(); tick();
  endtask

  task automatic t_reset();
    chk("R1 pend_n", pend_n, 1'b1);
    chk("R1 busy", bus_busy, 1'b0);
    chk("R1 dir", dir_tx, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 hold", scl_hold, 1'b0);
  endtask

  task automatic t_byte_done();
    byte_done = 1; tick(); clear_strobes();
    chk("R2 pend_n low", pend_n, 1'b0);
    chk("R2 irq pulse", irq, 1'b1);
    chk("R3 hold on", scl_hold, 1'b1);
    tick();
    chk("R2 irq one cycle", irq, 1'b0);
    chk("R2 pend_n stays", pend_n, 1'b0);
    wr_data = 1; tick(); clear_strobes();
    chk("R4 release", pend_n, 1'b1);
    chk("R3 hold off", scl_hold, 1'b0);
    chk("R2 no irq on rise", irq, 1'b0);
    wr_data = 1; byte_done = 1; tick(); clear_strobes();
    chk("R4 clear wins", pend_n, 1'b0);
    release_pend();
  endtask

  task automatic t_wait();
    ack_clk_mode = 1; wait_en = 0;
    data_done = 1; tick(); clear_strobes();
    chk("R5 no wait no clear", pend_n, 1'b1);
    wait_en = 1;
    byte_done = 1; tick(); clear_strobes();
    wr_clkctl = 1; tick(); clear_strobes();
    chk("R5 clkctl unarmed ignored", pend_n, 1'b0);
    release_pend();
    data_done = 1; tick(); clear_strobes();
    chk("R5 data_done clears", pend_n, 1'b0);
    chk("R5 irq", irq, 1'b1);
    wr_clkctl = 1; tick(); clear_strobes();
    chk("R5 clkctl armed release", pend_n, 1'b1);
    byte_done = 1; tick(); clear_strobes();
    wr_clkctl = 1; tick(); clear_strobes();
    chk("R5 wait disarmed after release", pend_n, 1'b0);
    release_pend();
    ack_clk_mode = 0; wait_en = 0;
  endtask

  task automatic t_addr();
    is_master = 0; addr_free = 0;
    addr_done = 1; tick(); clear_strobes();
    chk("R6 no match no clear", pend_n, 1'b1);
    addr_done = 1; gen_call = 1; tick(); clear_strobes();
    chk("R6 general call clears", pend_n, 1'b0);
    release_pend();
    addr_free = 1;
    addr_done = 1; tick(); clear_strobes();
    chk("R6 addr_free clears", pend_n, 1'b0);
    release_pend();
    is_master = 1;
    addr_done = 1; addr_match = 1; tick(); clear_strobes();
    chk("R6 master ignores", pend_n, 1'b1);
    is_master = 0; addr_free = 0;
  endtask

  task automatic bus_start();
    scl_in = 1; sda_in = 1; tick(8);
    sda_in = 0; tick(5);
  endtask

  task automatic bus_stop();
    scl_in = 0; tick(3); sda_in = 0; tick(3);
    scl_in = 1; tick(8); sda_in = 1; tick(5);
  endtask

  task automatic t_bus();
    scl_hi_min = 4'd3;
    bus_start();
    chk("R7 start sets busy", bus_busy, 1'b1);
    bus_stop();
    chk("R7 stop clears busy", bus_busy, 1'b0);
    scl_in = 0; tick(4); sda_in = 0; tick(4);
    chk("R7 sda fall scl low ignored", bus_busy, 1'b0);
    sda_in = 1; tick(4);
    scl_in = 1; tick(1); sda_in = 0; tick(6);
    chk("R7 short scl high filtered", bus_busy, 1'b0);
    scl_in = 0; tick(3); sda_in = 1; tick(3);
    scl_hi_min = 4'd0;
    scl_in = 1; tick(1); sda_in = 0; tick(6);
    chk("R7 zero filter accepts", bus_busy, 1'b1);
    bus_stop();
    scl_hi_min = 4'd3;
  endtask

  task automatic t_disable();
    byte_done = 1; tick(); clear_strobes();
    dir_wr = 1; dir_val = 1; tick(); clear_strobes();
    bus_start();
    en = 0; tick();
    chk("R8 pend forced", pend_n, 1'b1);
    chk("R8 busy forced", bus_busy, 1'b0);
    chk("R8 dir forced", dir_tx, 1'b0);
    bus_stop();
    saw_start = 0;
    bus_start();
    chk("R8 no start while off", saw_start, 1'b0);
    chk("R8 busy stays 0", bus_busy, 1'b0);
    en = 1; tick();
    bus_stop();
  endtask

  task automatic t_dir();
    is_master = 0; addr_free = 0;
    addr_match = 1; rx_rw = 1; addr_done = 1; tick(); clear_strobes();
    chk("R9 slave read sets dir", dir_tx, 1'b1);
    release_pend();
    bus_stop();
    chk("R10 stop clears dir", dir_tx, 1'b0);
    addr_free = 1;
    addr_match = 1; rx_rw = 1; tick(); clear_strobes();
    chk("R9 addr_free no set", dir_tx, 1'b0);
    addr_free = 0;
    dir_wr = 1; dir_val = 1; tick(); clear_strobes();
    chk("R11 sw write", dir_tx, 1'b1);
    arb_lost = 1; tick(); clear_strobes();
    chk("R10 arb_lost clears", dir_tx, 1'b0);
    dir_wr = 1; dir_val = 1; tick(); clear_strobes();
    start_blocked = 1; tick(); clear_strobes();
    chk("R10 start_blocked clears", dir_tx, 1'b0);
    dir_wr = 1; dir_val = 1; tick(); clear_strobes();
    nack = 1; tick(); clear_strobes();
    chk("R10 slave nack clears", dir_tx, 1'b0);
    is_master = 1;
    dir_wr = 1; dir_val = 1; tick(); clear_strobes();
    nack = 1; tick(); clear_strobes();
    chk("R10 master nack keeps", dir_tx, 1'b1);
    bus_start();
    chk("R10 master start keeps", dir_tx, 1'b1);
    is_master = 0;
    bus_stop();
    dir_wr = 1; dir_val = 1; tick(); clear_strobes();
    bus_start();
    chk("R10 slave start clears", dir_tx, 1'b0);
    bus_stop();
    dir_wr = 1; dir_val = 1; arb_lost = 1; tick(); clear_strobes();
    chk("R11 hw clear beats sw", dir_tx, 1'b0);
    dir_wr = 1; dir_val = 0; addr_match = 1; rx_rw = 1; tick(); clear_strobes();
    chk("R11 hw set beats sw", dir_tx, 1'b1);
    addr_match = 1; rx_rw = 1; arb_lost = 1; tick(); clear_strobes();
    chk("R11 clear beats set", dir_tx, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1; tick(2);
    t_reset();
    en = 1; tick(2);
    t_byte_done();
    t_wait();
    t_addr();
    t_bus();
    t_disable();
    t_dir();
    tick(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule